// File: doc/BRIEF.md
# Flag Byte Merge Unit

This execution unit copies one packed status byte into a general-purpose destination register. The byte is built either from the seven per-thread predicates or from the four condition flags. It is then blended bit by bit into one chosen byte lane of a source register `ra_i`. An 8-bit select mask controls the blend: a set mask bit takes the status bit, and a clear mask bit keeps the source bit. The other three lanes of the source pass through unchanged.

The mask comes from one of three operand forms: a register value, a constant value, or a 20-bit immediate that is sign-extended. Only the lowest byte of the chosen mask has any effect. A short form needs no source and no mask, and writes the status byte zero-extended. Each operation carries a guard predicate, which may be negated. When the guard evaluates false, the result is discarded. The destination write appears one clock after the issue cycle, and a new operation may be issued on every cycle.

Top module: `flagmerge_unit`

## Requirements
- R1: With `src_sel_i`=0 (predicates), status bit k equals `pred_i[k]` for k=0..6, and status bit 7 is always 0.
- R2: With `src_sel_i`=1 (flags), `flags_i` bits 0..3 (zero, sign, carry, overflow) appear as status bits 0..3, and status bits 7..4 are 0.
- R3: For each b in 0..7, result bit (8*lane+b) takes status bit b when mask bit b is 1, and takes `ra_i` bit (8*lane+b) when mask bit b is 0.
- R4: `lane_i` values 0..3 select `ra_i` bits [7:0], [15:8], [23:16] and [31:24] as the merge target. All bits outside the selected lane equal `ra_i`.
- R5: When `short_form_i`=1, the unit behaves as lane 0 with the source taken as zero and mask 0xFF, so the result is the zero-extended status byte.
- R6: `mask_kind_i` 0 takes `mask_reg_i`, 1 takes `mask_const_i` and 2 takes `mask_imm_i` sign-extended to 32 bits. In every form, mask bits 31:8 have no effect on the result.
- R7: The guard is `pred_i[guard_idx_i]` XOR `guard_neg_i`. When it is false, `wr_en_o` stays 0 on the following cycle and `wr_data_o` keeps its previous value.
- R8: `guard_idx_i`=7 is an always-true predicate. Without negation the operation always writes, and with negation it never writes.
- R9: A valid operation whose guard is true raises `wr_en_o` with its result exactly one cycle later. Issues on consecutive cycles each produce their own write.
- R10: While reset is active and after its release, `wr_en_o` is 0 and `wr_data_o` is 0 until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operation issued this cycle |
| src_sel_i | input | 1 | 0: predicate byte, 1: condition flag byte |
| lane_i | input | 2 | Target byte lane of the source register |
| short_form_i | input | 1 | Short form: zero source, full mask, lane 0 |
| ra_i | input | 32 | Source register value |
| mask_kind_i | input | 2 | Mask operand form: 0 register, 1 constant, 2 immediate |
| mask_reg_i | input | 32 | Register mask operand |
| mask_const_i | input | 32 | Constant mask operand |
| mask_imm_i | input | 20 | Immediate mask operand, sign-extended |
| pred_i | input | 7 | Per-thread predicates P0..P6 |
| flags_i | input | 4 | {overflow, carry, sign, zero} |
| guard_idx_i | input | 3 | Guard predicate index, 7 = always true |
| guard_neg_i | input | 1 | Invert the guard |
| wr_en_o | output | 1 | Destination write enable |
| wr_data_o | output | 32 | Destination write value |

## Verification
The hardest case to reach from the ports is a mask whose ignored upper bits are set by sign extension while its low byte is partly set. The stimulus drives an immediate with bit 19 set and a mixed low byte, and also a constant whose upper bits are all ones but whose low byte is zero. In the second case the result must equal the source exactly. Guard checks cover a false guard between two writes, which confirms that the destination value holds, and negation of the always-true index.

// File: rtl/flagmerge_pkg.sv
package flagmerge_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_PRED  = 7;
  localparam int N_FLAGS = 4;

  typedef enum logic {SRC_PRED = 1'b0, SRC_FLAG = 1'b1} src_sel_e;
  typedef enum logic [1:0] {
    MK_REG = 2'd0, MK_CONST = 2'd1, MK_IMM = 2'd2, MK_RSVD = 2'd3
  } mask_kind_e;

  // predicates occupy the low bits, top bit cleared
  function automatic logic [BYTE_W-1:0] pack_pred(input logic [N_PRED-1:0] p);
    return {{(BYTE_W-N_PRED){1'b0}}, p};
  endfunction

  // flags {OF,CF,SF,ZF} occupy the low nibble
  function automatic logic [BYTE_W-1:0] pack_flags(input logic [N_FLAGS-1:0] f);
    return {{(BYTE_W-N_FLAGS){1'b0}}, f};
  endfunction

  function automatic logic [BYTE_W-1:0] blend(input logic [BYTE_W-1:0] keep,
                                              input logic [BYTE_W-1:0] ins,
                                              input logic [BYTE_W-1:0] sel);
    return (keep & ~sel) | (ins & sel);
  endfunction
endpackage

// File: rtl/flag_pack.sv
module flag_pack
  import flagmerge_pkg::*;
(
  input  logic               src_sel_i,
  input  logic [N_PRED-1:0]  pred_i,
  input  logic [N_FLAGS-1:0] flags_i,
  output logic [BYTE_W-1:0]  byte_o
);
  always_comb begin
    if (src_sel_e'(src_sel_i) == SRC_FLAG) byte_o = pack_flags(flags_i);
    else                                   byte_o = pack_pred(pred_i);
  end
endmodule

// File: rtl/mask_select.sv
module mask_select
  import flagmerge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20
) (
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  always_comb begin
    unique case (mask_kind_e'(kind_i))
      MK_CONST: word_o = const_i;
      MK_IMM:   word_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      default:  word_o = reg_i;
    endcase
  end
endmodule

// File: rtl/guard_eval.sv
module guard_eval
  import flagmerge_pkg::*;
#(
  parameter int GI_W = 3
) (
  input  logic [N_PRED-1:0] pred_i,
  input  logic [GI_W-1:0]   idx_i,
  input  logic              neg_i,
  output logic              pass_o
);
  localparam int EXT_N = 2**GI_W;
  logic [EXT_N-1:0] pred_ext;

  // indices past the last predicate read as always-true
  assign pred_ext = {{(EXT_N-N_PRED){1'b1}}, pred_i};
  assign pass_o   = pred_ext[idx_i] ^ neg_i;
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import flagmerge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                    src_i,
  input  logic [$clog2(DATA_W/BYTE_W)-1:0]     lane_i,
  input  logic [BYTE_W-1:0]                    ins_i,
  input  logic [BYTE_W-1:0]                    sel_i,
  output logic [DATA_W-1:0]                    res_o
);
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign res_o[g*BYTE_W +: BYTE_W] = (lane_i == LANE_W'(g))
      ? blend(src_i[g*BYTE_W +: BYTE_W], ins_i, sel_i)
      : src_i[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/flagmerge_unit.sv
module flagmerge_unit
  import flagmerge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20,
  parameter int GI_W   = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 in_valid_i,
  input  logic                                 src_sel_i,
  input  logic [$clog2(DATA_W/BYTE_W)-1:0]     lane_i,
  input  logic                                 short_form_i,
  input  logic [DATA_W-1:0]                    ra_i,
  input  logic [1:0]                           mask_kind_i,
  input  logic [DATA_W-1:0]                    mask_reg_i,
  input  logic [DATA_W-1:0]                    mask_const_i,
  input  logic [IMM_W-1:0]                     mask_imm_i,
  input  logic [N_PRED-1:0]                    pred_i,
  input  logic [N_FLAGS-1:0]                   flags_i,
  input  logic [GI_W-1:0]                      guard_idx_i,
  input  logic                                 guard_neg_i,
  output logic                                 wr_en_o,
  output logic [DATA_W-1:0]                    wr_data_o
);
  localparam int LANE_W = $clog2(DATA_W / BYTE_W);

  // named internal events for the checker
  logic [BYTE_W-1:0] status_byte_w;
  logic [DATA_W-1:0] mask_word_w;
  logic              guard_ok_w;
  logic              fire_w;
  logic [DATA_W-1:0] merged_w;

  logic [DATA_W-1:0] src_eff;
  logic [LANE_W-1:0] lane_eff;
  logic [BYTE_W-1:0] sel_eff;

  flag_pack u_pack (
    .src_sel_i (src_sel_i),
    .pred_i    (pred_i),
    .flags_i   (flags_i),
    .byte_o    (status_byte_w)
  );

  mask_select #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mask (
    .kind_i  (mask_kind_i),
    .reg_i   (mask_reg_i),
    .const_i (mask_const_i),
    .imm_i   (mask_imm_i),
    .word_o  (mask_word_w)
  );

  guard_eval #(.GI_W(GI_W)) u_guard (
    .pred_i (pred_i),
    .idx_i  (guard_idx_i),
    .neg_i  (guard_neg_i),
    .pass_o (guard_ok_w)
  );

  // short form: zero source, full mask, lane 0
  assign src_eff  = short_form_i ? '0 : ra_i;
  assign lane_eff = short_form_i ? '0 : lane_i;
  assign sel_eff  = short_form_i ? {BYTE_W{1'b1}} : mask_word_w[BYTE_W-1:0];

  lane_merge #(.DATA_W(DATA_W)) u_merge (
    .src_i  (src_eff),
    .lane_i (lane_eff),
    .ins_i  (status_byte_w),
    .sel_i  (sel_eff),
    .res_o  (merged_w)
  );

  assign fire_w = in_valid_i & guard_ok_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= fire_w;
      if (fire_w) wr_data_o <= merged_w;
    end
  end
endmodule

// File: rtl/flagmerge_chk.sv
module flagmerge_chk
  import flagmerge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20,
  parameter int GI_W   = 3
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic                                 in_valid_i,
  input logic                                 src_sel_i,
  input logic [$clog2(DATA_W/BYTE_W)-1:0]     lane_i,
  input logic                                 short_form_i,
  input logic [DATA_W-1:0]                    ra_i,
  input logic [1:0]                           mask_kind_i,
  input logic [IMM_W-1:0]                     mask_imm_i,
  input logic [GI_W-1:0]                      guard_idx_i,
  input logic                                 guard_neg_i,
  input logic [BYTE_W-1:0]                    status_byte_w,
  input logic [DATA_W-1:0]                    mask_word_w,
  input logic                                 fire_w,
  input logic [DATA_W-1:0]                    merged_w,
  input logic                                 wr_en_o,
  input logic [DATA_W-1:0]                    wr_data_o
);
  localparam logic [GI_W-1:0] ALWAYS_IDX = GI_W'(N_PRED);

  p_pred_top_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 1'b0) |-> (status_byte_w[BYTE_W-1] == 1'b0));

  p_flag_high_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 1'b1) |-> (status_byte_w[BYTE_W-1:N_FLAGS] == '0));

  p_lane0_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_w && !short_form_i && lane_i == '0)
      |=> (wr_data_o[DATA_W-1:BYTE_W] == $past(ra_i[DATA_W-1:BYTE_W])));

  p_short_zext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_w && short_form_i) |=> (wr_data_o[DATA_W-1:BYTE_W] == '0));

  p_imm_sext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_kind_i == 2'd2) |->
      (mask_word_w[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){mask_imm_i[IMM_W-1]}}));

  p_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_w |=> !wr_en_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_w |=> $stable(wr_data_o));

  p_always_true_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && guard_idx_i == ALWAYS_IDX) |-> (fire_w == !guard_neg_i));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_w |=> (wr_en_o && wr_data_o == $past(merged_w)));
endmodule

bind flagmerge_unit flagmerge_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .GI_W(GI_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .src_sel_i     (src_sel_i),
  .lane_i        (lane_i),
  .short_form_i  (short_form_i),
  .ra_i          (ra_i),
  .mask_kind_i   (mask_kind_i),
  .mask_imm_i    (mask_imm_i),
  .guard_idx_i   (guard_idx_i),
  .guard_neg_i   (guard_neg_i),
  .status_byte_w (status_byte_w),
  .mask_word_w   (mask_word_w),
  .fire_w        (fire_w),
  .merged_w      (merged_w),
  .wr_en_o       (wr_en_o),
  .wr_data_o     (wr_data_o)
);

// File: tb/flagmerge_unit_tb_top.sv
module flagmerge_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        src_sel = 1'b0;
  logic [1:0]  lane = '0;
  logic        short_form = 1'b0;
  logic [31:0] ra = '0;
  logic [1:0]  mask_kind = '0;
  logic [31:0] mask_reg = '0;
  logic [31:0] mask_const = '0;
  logic [19:0] mask_imm = '0;
  logic [6:0]  pred = '0;
  logic [3:0]  flags = '0;
  logic [2:0]  guard_idx = 3'd7;
  logic        guard_neg = 1'b0;
  logic        wr_en;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_data = '0;
  bit done = 0;

  typedef struct {
    logic        en;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  flagmerge_unit dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .src_sel_i    (src_sel),
    .lane_i       (lane),
    .short_form_i (short_form),
    .ra_i         (ra),
    .mask_kind_i  (mask_kind),
    .mask_reg_i   (mask_reg),
    .mask_const_i (mask_const),
    .mask_imm_i   (mask_imm),
    .pred_i       (pred),
    .flags_i      (flags),
    .guard_idx_i  (guard_idx),
    .guard_neg_i  (guard_neg),
    .wr_en_o      (wr_en),
    .wr_data_o    (wr_data)
  );

  // reference result, written bit-wise from the requirements
  function automatic logic [31:0] ref_result(
      input logic s, input logic [1:0] ln, input logic sh, input logic [31:0] a,
      input logic [1:0] mk, input logic [31:0] mr, input logic [31:0] mc,
      input logic [19:0] mi, input logic [6:0] p, input logic [3:0] f);
    logic [7:0]  st;
    logic [31:0] m;
    logic [31:0] r;
    int          base;
    for (int i = 0; i < 8; i++) begin
      if (!s) st[i] = (i < 7) ? p[i] : 1'b0;   // R1
      else    st[i] = (i < 4) ? f[i] : 1'b0;   // R2
    end
    if (mk == 2'd1)      m = mc;
    else if (mk == 2'd2) m = {{12{mi[19]}}, mi};
    else                 m = mr;
    r = a;
    base = 8 * int'(ln);
    if (sh) begin r = 32'd0; base = 0; m = 32'hFF; end
    for (int b = 0; b < 8; b++)
      if (m[b]) r[base + b] = st[b];
    return r;
  endfunction

  task automatic issue(input logic s, input logic [1:0] ln, input logic sh,
                       input logic [31:0] a, input logic [1:0] mk,
                       input logic [31:0] mr, input logic [31:0] mc,
                       input logic [19:0] mi, input logic [6:0] p,
                       input logic [3:0] f, input logic [2:0] gi,
                       input logic gn, input string tag);
    exp_t e;
    logic ok;
    @(negedge clk);
    in_valid = 1'b1; src_sel = s; lane = ln; short_form = sh; ra = a;
    mask_kind = mk; mask_reg = mr; mask_const = mc; mask_imm = mi;
    pred = p; flags = f; guard_idx = gi; guard_neg = gn;
    ok = ((gi == 3'd7) ? 1'b1 : p[gi]) ^ gn;
    e.en = ok;
    if (ok) last_data = ref_result(s, ln, sh, a, mk, mr, mc, mi, p, f);
    e.data = last_data;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0;
    ra = 32'hA5A5A5A5;
    e.en = 1'b0; e.data = last_data; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one expected item per clock after reset
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (wr_en !== e.en || wr_data !== e.data) begin
          errors++;
          $display("FAIL %s: got en=%0b data=%08h expected en=%0b data=%08h",
                   e.tag, wr_en, wr_data, e.en, e.data);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (wr_en !== 1'b0 || wr_data !== 32'd0) begin
      errors++;
      $display("FAIL R10 in reset: got en=%0b data=%08h expected 0/0", wr_en, wr_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (wr_en !== 1'b0 || wr_data !== 32'd0) begin
      errors++;
      $display("FAIL R10 after release: got en=%0b data=%08h expected 0/0", wr_en, wr_data);
    end

    // R5 and R1: short form with predicates, bit 7 zero
    issue(0, 2'd3, 1, 32'hFFFFFFFF, 0, 32'h0, 0, 0, 7'h7F, 4'h0, 3'd7, 0, "R1 R5 short pred");
    issue(0, 2'd0, 1, 32'h0, 0, 32'h0, 0, 0, 7'h55, 4'hF, 3'd7, 0, "R1 short pred 55");
    // R2: short form with flags
    issue(1, 2'd0, 1, 32'h12345678, 0, 32'h0, 0, 0, 7'h7F, 4'hB, 3'd7, 0, "R2 R5 short flags");
    // R3: single-bit mask keeps the rest
    issue(1, 2'd0, 0, 32'hDEADBEEF, 0, 32'h01, 0, 0, 7'h00, 4'hE, 3'd7, 0, "R3 mask bit0");
    issue(1, 2'd0, 0, 32'h00000000, 0, 32'h08, 0, 0, 7'h00, 4'h8, 3'd7, 0, "R3 mask bit3");
    issue(0, 2'd0, 0, 32'hCAFEF00D, 0, 32'hA5, 0, 0, 7'h5A, 4'h0, 3'd7, 0, "R3 mixed mask");
    // R4: every lane
    for (int l = 0; l < 4; l++)
      issue(0, 2'(l), 0, 32'h12345678, 0, 32'hFF, 0, 0, 7'h6C, 4'h0, 3'd7, 0, "R4 lane");
    issue(1, 2'd2, 0, 32'hFFFFFFFF, 0, 32'h0F, 0, 0, 7'h00, 4'h5, 3'd7, 0, "R4 lane2 flags");
    // R6: operand forms and ignored upper bits
    issue(0, 2'd1, 0, 32'h00000000, 1, 32'h0, 32'hFFFFFF3C, 0, 7'h7F, 4'h0, 3'd7, 0, "R6 const");
    issue(0, 2'd0, 0, 32'h89ABCDEF, 1, 32'hFF, 32'hFFFFFF00, 0, 7'h00, 4'h0, 3'd7, 0, "R6 const upper only");
    issue(1, 2'd3, 0, 32'h00FF00FF, 2, 32'hFF, 0, 20'h80F0F, 7'h00, 4'h9, 3'd7, 0, "R6 imm sext");
    issue(0, 2'd0, 0, 32'h11111111, 0, 32'hFFFFFF00, 32'hFF, 20'hFFFFF, 7'h7F, 4'h0, 3'd7, 0, "R6 reg upper only");
    // R7: false guard holds data, negation
    issue(0, 2'd0, 1, 32'h0, 0, 0, 0, 0, 7'h7B, 4'h0, 3'd2, 0, "R7 false guard");
    issue(0, 2'd0, 1, 32'h0, 0, 0, 0, 0, 7'h7B, 4'h0, 3'd2, 1, "R7 negated guard");
    issue(0, 2'd0, 1, 32'h0, 0, 0, 0, 0, 7'h40, 4'h0, 3'd6, 1, "R7 negated true");
    idle("R7 idle");
    // R8: always-true index
    issue(1, 2'd0, 1, 32'h0, 0, 0, 0, 0, 7'h00, 4'h3, 3'd7, 1, "R8 never");
    issue(1, 2'd0, 1, 32'h0, 0, 0, 0, 0, 7'h00, 4'h6, 3'd7, 0, "R8 always");
    // R9: back-to-back stream then idle
    for (int k = 0; k < 6; k++)
      issue(k[0], 2'(k), 0, 32'h01020304 * (k + 1), 0, 32'h33 << k[1:0], 0, 0,
            7'(k * 19), 4'(k * 5), 3'd7, 0, "R9 stream");
    idle("R9 drain");
    idle("R9 drain");
    @(posedge clk); #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule